// File: doc/BRIEF.md
# DMA Channel Address and Count Register Bank

This block keeps the programmable address and count state of a four-channel DMA controller. Each channel has a 16-bit start address and a 16-bit terminal count. Software reaches them over a byte-wide port bus. A current address and a transferred-byte count are held alongside that state. Because every register is 16 bits wide and the bus carries one byte, a single byte pointer shared by all channels picks which half each access touches. The pointer flips after every channel-register access.

Reads are not taken from stored copies. The address reading is the current address moved forward or back by the transferred count, with the direction given per channel. The count reading is the programmed count minus the progress so far. An external transfer agent reports progress on a per-channel strobe. For each channel the block presents the length of the block that one programmed transfer covers. The parameter `WIDTH_SHIFT` selects byte-wide addressing (0) or word-wide addressing (1). It affects port decoding, address scaling and byte extraction.

Top module: `dma_chan_regs`

## Requirements
- R1: The port index is `port_addr_i[WIDTH_SHIFT +: 4]`. Indices 0 to 7 select a channel register: the channel number is index / 2, an even index selects the address register and an odd index selects the count register. An access to one channel leaves every other channel unchanged.
- R2: The byte pointer inverts on every read or write that hits index 0 to 7. Accesses to indices 8 to 15 leave the pointer and all registers unchanged, and a read of such an index returns 0.
- R3: `clr_ptr_i` forces the byte pointer to 0 at the next edge. This takes priority over an access made in the same cycle, but that access still uses the pointer value it found.
- R4: A write made while the pointer is 0 replaces bits [7:0] of the selected start register only. The current address and the transferred count are left as they were.
- R5: A write made while the pointer is 1 replaces bits [15:8] of the selected start register. It also loads the channel's current address with (start address << WIDTH_SHIFT), using the new value when the address register is the one written, and it resets the transferred count to 0.
- R6: The count reading is ((start count << WIDTH_SHIFT) − transferred count), taken modulo 2^(16+WIDTH_SHIFT).
- R7: The address reading is current address + transferred count when `dir_down_i[c]` is 0, and current address − transferred count when it is 1, taken modulo 2^(16+WIDTH_SHIFT).
- R8: A read returns bits [WIDTH_SHIFT + 8·p +: 8] of the reading, where p is the pointer value before the access flips it.
- R9: `blk_size_o[c*BLK_W +: BLK_W]` equals (start count of channel c + 1) << WIDTH_SHIFT.
- R10: A pulse on `prog_we_i[c]` loads `prog_val_i` into channel c's transferred count. A pointer-1 write to the same channel in the same cycle wins, and the count becomes 0.
- R11: While `rst_ni` is low, all start registers, current addresses, transferred counts and the byte pointer are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| port_addr_i | input | ADDR_W | Port address of the bus access |
| port_wr_i | input | 1 | Write strobe, one cycle per byte |
| port_rd_i | input | 1 | Read strobe, one cycle per byte |
| port_wdata_i | input | 8 | Write byte |
| port_rdata_o | output | 8 | Read byte, valid while port_rd_i is high |
| clr_ptr_i | input | 1 | Forces the byte pointer to 0 |
| dir_down_i | input | NCH | Per-channel address direction, 1 = decrement |
| prog_we_i | input | NCH | Per-channel transferred-count load strobe |
| prog_val_i | input | PROG_W | Transferred-count value to load |
| blk_size_o | output | NCH*BLK_W | Per-channel transfer block length |

## Verification
The bench targets four corner cases:
- **Pointer must ignore indices 8 to 15.** A design that flipped the pointer there would return the high byte where the low byte is expected.
- **Pointer clear arriving with a read.** A design that let the flip win over the clear would hand out the high byte on the following read.
- **Readings that wrap.** Progress is driven past the programmed count, and the address direction is flipped. A design that saturated the result, or ignored the direction, returns wrong bytes.
- **High-byte count write in the same cycle as a progress strobe.** A design that let the strobe win would show a non-zero remaining count. The bench also checks that a low-byte write leaves the current address alone, and that a high-byte count write reloads the address from the start register.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int BASE_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic {
    SEL_ADDR = 1'b0,
    SEL_CNT  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/dma_port_decode.sv
module dma_port_decode
  import dma_regs_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int WIDTH_SHIFT = 0,
  parameter int NCH         = 4,
  parameter int CH_W        = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [CH_W-1:0]   ch_o,
  output reg_sel_e          sel_o
);
  logic [3:0] idx;

  assign idx   = addr_i[WIDTH_SHIFT +: 4];
  assign hit_o = ({1'b0, idx} < 5'(2 * NCH));
  assign ch_o  = CH_W'(idx >> 1);
  assign sel_o = reg_sel_e'(idx[0]);
endmodule

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output logic ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= 1'b0;
    else if (clr_i)  ptr_o <= 1'b0;
    else if (step_i) ptr_o <= ~ptr_o;
  end

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clr_i) |=> (ptr_o != $past(ptr_o)));
  p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clr_i) |=> $stable(ptr_o));
  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !ptr_o);
endmodule

// File: rtl/dma_chan_slot.sv
module dma_chan_slot
  import dma_regs_pkg::*;
#(
  parameter int WIDTH_SHIFT = 0,
  parameter int PROG_W      = 18,
  parameter int BLK_W       = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  reg_sel_e          sel_i,
  input  logic              hi_i,
  input  logic [7:0]        wdata_i,
  input  logic              dir_down_i,
  input  logic              prog_we_i,
  input  logic [PROG_W-1:0] prog_val_i,
  output logic [BASE_W+WIDTH_SHIFT-1:0] addr_val_o,
  output logic [BASE_W+WIDTH_SHIFT-1:0] cnt_val_o,
  output logic [BLK_W-1:0]  blk_o
);
  localparam int CUR_W = BASE_W + WIDTH_SHIFT;
  localparam int VAL_W = BASE_W + WIDTH_SHIFT;

  logic [BASE_W-1:0] base_addr, base_cnt, reload_src;
  logic [CUR_W-1:0]  cur_addr;
  logic [PROG_W-1:0] prog;
  logic [VAL_W-1:0]  prog_v;
  logic              wr_lo, wr_hi;

  assign wr_lo = wr_i && !hi_i;
  assign wr_hi = wr_i && hi_i;
  // high-byte address write reloads from the new value
  assign reload_src = (sel_i == SEL_ADDR) ? {wdata_i, base_addr[7:0]} : base_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      prog      <= '0;
    end else begin
      if (wr_lo) begin
        if (sel_i == SEL_ADDR) base_addr[7:0] <= wdata_i;
        else                   base_cnt[7:0]  <= wdata_i;
      end
      if (wr_hi) begin
        if (sel_i == SEL_ADDR) base_addr[15:8] <= wdata_i;
        else                   base_cnt[15:8]  <= wdata_i;
        cur_addr <= CUR_W'(reload_src) << WIDTH_SHIFT;
        prog     <= '0;
      end else if (prog_we_i) begin
        prog <= prog_val_i;
      end
    end
  end

  assign prog_v     = VAL_W'(prog);
  assign addr_val_o = dir_down_i ? (VAL_W'(cur_addr) - prog_v) : (VAL_W'(cur_addr) + prog_v);
  assign cnt_val_o  = (VAL_W'(base_cnt) << WIDTH_SHIFT) - prog_v;
  assign blk_o      = (BLK_W'(base_cnt) + BLK_W'(1)) << WIDTH_SHIFT;

  p_lo_keeps_cur_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo |=> $stable(cur_addr));
  p_lo_keeps_prog_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo && !prog_we_i) |=> $stable(prog));
  p_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi |=> (prog == '0) && (cur_addr == (CUR_W'(base_addr) << WIDTH_SHIFT)));
  p_prog_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_we_i && !wr_hi) |=> (prog == $past(prog_val_i)));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int WIDTH_SHIFT = 0,
  parameter int NCH         = 4,
  parameter int ADDR_W      = 8,
  parameter int PROG_W      = BASE_W + 2,
  parameter int BLK_W       = BASE_W + 1 + WIDTH_SHIFT
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    port_addr_i,
  input  logic                 port_wr_i,
  input  logic                 port_rd_i,
  input  logic [7:0]           port_wdata_i,
  output logic [7:0]           port_rdata_o,
  input  logic                 clr_ptr_i,
  input  logic [NCH-1:0]       dir_down_i,
  input  logic [NCH-1:0]       prog_we_i,
  input  logic [PROG_W-1:0]    prog_val_i,
  output logic [NCH*BLK_W-1:0] blk_size_o
);
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int VAL_W = BASE_W + WIDTH_SHIFT;

  logic        hit, ptr, step;
  logic [CH_W-1:0] ch;
  reg_sel_e    sel;
  logic [VAL_W-1:0] addr_val [NCH];
  logic [VAL_W-1:0] cnt_val  [NCH];
  logic [VAL_W-1:0] rd_val, rd_shift;

  dma_port_decode #(
    .ADDR_W(ADDR_W), .WIDTH_SHIFT(WIDTH_SHIFT), .NCH(NCH), .CH_W(CH_W)
  ) u_dec (
    .addr_i(port_addr_i), .hit_o(hit), .ch_o(ch), .sel_o(sel)
  );

  assign step = hit && (port_wr_i || port_rd_i);

  dma_byte_ptr u_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_ptr_i), .step_i(step), .ptr_o(ptr)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic wr_c;
    assign wr_c = port_wr_i && hit && (ch == CH_W'(c));

    dma_chan_slot #(
      .WIDTH_SHIFT(WIDTH_SHIFT), .PROG_W(PROG_W), .BLK_W(BLK_W)
    ) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (wr_c),
      .sel_i      (sel),
      .hi_i       (ptr),
      .wdata_i    (port_wdata_i),
      .dir_down_i (dir_down_i[c]),
      .prog_we_i  (prog_we_i[c]),
      .prog_val_i (prog_val_i),
      .addr_val_o (addr_val[c]),
      .cnt_val_o  (cnt_val[c]),
      .blk_o      (blk_size_o[c*BLK_W +: BLK_W])
    );
  end

  assign rd_val       = (sel == SEL_CNT) ? cnt_val[ch] : addr_val[ch];
  assign rd_shift     = rd_val >> (WIDTH_SHIFT + (ptr ? 8 : 0));
  assign port_rdata_o = (port_rd_i && hit) ? rd_shift[7:0] : 8'h00;

  p_foreign_idx_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_rd_i && port_addr_i[WIDTH_SHIFT + 3]) |-> (port_rdata_o == 8'h00));
endmodule

// File: tb/sim_dma_chan_regs.sv
module sim_dma_chan_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NCH    = 4;
  localparam int PROG_W = 18;
  localparam int BLK_W  = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0, clr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [NCH-1:0] dir_dn = '0, pwe = '0;
  logic [PROG_W-1:0] pval = '0;
  logic [NCH*BLK_W-1:0] blk;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .port_addr_i(addr), .port_wr_i(wr), .port_rd_i(rd),
    .port_wdata_i(wdata), .port_rdata_o(rdata), .clr_ptr_i(clr), .dir_down_i(dir_dn),
    .prog_we_i(pwe), .prog_val_i(pval), .blk_size_o(blk)
  );

  // monitor: compares each scored read a quarter period after it is driven
  always begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    if (rd && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (rdata !== e) begin
        n_fail++;
        $display("FAIL %s: read port %0d got %02h expected %02h", t, addr, rdata, e);
      end
    end
  end

  task automatic rd_b(input logic [7:0] a, input logic [7:0] e, input string t,
                      input logic with_clr = 1'b0);
    @(negedge clk);
    addr = a; rd = 1'b1; clr = with_clr;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd = 1'b0; clr = 1'b0;
  endtask

  task automatic rd_raw(input logic [7:0] a);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wr_b(input logic [7:0] a, input logic [7:0] d,
                      input logic [NCH-1:0] we = '0, input logic [PROG_W-1:0] v = '0);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1; pwe = we; pval = v;
    @(negedge clk);
    wr = 1'b0; pwe = '0;
  endtask

  task automatic prog_b(input int c, input logic [PROG_W-1:0] v);
    @(negedge clk);
    pwe = '0; pwe[c] = 1'b1; pval = v;
    @(negedge clk);
    pwe = '0;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] e);
    n_chk++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", t, act, e);
    end
  endtask

  function automatic logic [BLK_W-1:0] blk_of(input int c);
    return blk[c*BLK_W +: BLK_W];
  endfunction

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 blk ch0 during reset", 32'(blk_of(0)), 32'h1);
    rst_n = 1'b1;
    rd_b(8'd0, 8'h00, "R11 addr lo");
    rd_b(8'd0, 8'h00, "R11 addr hi");
    rd_b(8'd1, 8'h00, "R11 cnt lo");
    rd_b(8'd1, 8'h00, "R11 cnt hi");
    chk("R9 blk ch0 after reset", 32'(blk_of(0)), 32'h1);

    // R1 R5 R8: program channel 1 address
    wr_b(8'd2, 8'h34);
    wr_b(8'd2, 8'h12);
    rd_b(8'd2, 8'h34, "R8 addr low byte");
    rd_b(8'd2, 8'h12, "R8 addr high byte");

    // R9 count programming
    wr_b(8'd3, 8'hFF);
    wr_b(8'd3, 8'h00);
    @(negedge clk);
    chk("R9 blk ch1", 32'(blk_of(1)), 32'h100);

    // R6 R7 R10 progress
    prog_b(1, 18'h10);
    rd_b(8'd3, 8'hEF, "R6 remaining lo");
    rd_b(8'd3, 8'h00, "R6 remaining hi");
    rd_b(8'd2, 8'h44, "R7 up lo");
    rd_b(8'd2, 8'h12, "R7 up hi");
    dir_dn[1] = 1'b1;
    rd_b(8'd2, 8'h24, "R7 down lo");
    rd_b(8'd2, 8'h12, "R7 down hi");
    dir_dn[1] = 1'b0;

    // R4 low-byte write leaves current address and progress
    wr_b(8'd2, 8'h99);
    pulse_clr();
    rd_b(8'd2, 8'h44, "R4 cur addr kept lo");
    rd_b(8'd2, 8'h12, "R4 cur addr kept hi");
    rd_b(8'd3, 8'hEF, "R4 progress kept");
    rd_b(8'd3, 8'h00, "R4 progress kept hi");

    // R2 indices 8..15 ignored
    wr_b(8'd8, 8'h55);
    rd_raw(8'd13);
    rd_b(8'd2, 8'h44, "R2 pointer unmoved by foreign index");
    rd_b(8'd2, 8'h12, "R2 follow-up hi");

    // R3 clear with read in the same cycle
    rd_b(8'd2, 8'h44, "R3 read with clear", 1'b1);
    rd_b(8'd2, 8'h44, "R3 pointer forced low");
    rd_b(8'd2, 8'h12, "R3 then high");

    // R5 high write reloads current address, clears progress
    wr_b(8'd2, 8'h56);
    wr_b(8'd2, 8'hAB);
    rd_b(8'd2, 8'h56, "R5 reload lo");
    rd_b(8'd2, 8'hAB, "R5 reload hi");
    rd_b(8'd3, 8'hFF, "R5 progress cleared lo");
    rd_b(8'd3, 8'h00, "R5 progress cleared hi");

    // R6 wrap, R7 downward wrap
    prog_b(1, 18'h105);
    rd_b(8'd3, 8'hFA, "R6 wrap lo");
    rd_b(8'd3, 8'hFF, "R6 wrap hi");
    dir_dn[1] = 1'b1;
    rd_b(8'd2, 8'h51, "R7 down lo");
    rd_b(8'd2, 8'hAA, "R7 down hi");
    dir_dn[1] = 1'b0;

    // R10 high write beats coincident strobe
    wr_b(8'd3, 8'h20);
    wr_b(8'd3, 8'h00, 4'b0010, 18'h7);
    rd_b(8'd3, 8'h20, "R10 write wins lo");
    rd_b(8'd3, 8'h00, "R10 write wins hi");
    chk("R9 blk ch1 reprogrammed", 32'(blk_of(1)), 32'h21);

    // R1 isolation
    rd_b(8'd6, 8'h00, "R1 ch3 addr lo");
    rd_b(8'd6, 8'h00, "R1 ch3 addr hi");
    rd_b(8'd7, 8'h00, "R1 ch3 cnt lo");
    rd_b(8'd7, 8'h00, "R1 ch3 cnt hi");
    chk("R1 blk ch3", 32'(blk_of(3)), 32'h1);
    chk("R1 blk ch0", 32'(blk_of(0)), 32'h1);

    // R11 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_b(8'd2, 8'h00, "R11 post reset lo");
    rd_b(8'd2, 8'h00, "R11 post reset hi");
    chk("R11 blk ch1 post reset", 32'(blk_of(1)), 32'h1);

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule